// File: doc/BRIEF.md
# Multi-channel interval timer

A bank of six independent down-counting timers behind a small memory-mapped register port. Each channel chooses one of four tick-enable inputs as its time base and divides it by a power of two. It counts an interval down to zero and raises its own interrupt line when it expires. A channel runs either periodically, reloading itself and counting on, or once, after which it switches itself off.

The reference clocks are not generated here. They arrive as single-cycle tick-enable pulses on `tick_i`, synchronous to `clk`. Software programs the channels, reads their live counts, and manages the interrupts. It does this through a shared enable mask and a shared status register whose bits are cleared by writing ones. Two scratch words are kept for software and have no effect on the timers.

Top module: `pit_timer_bank`

## Requirements
- R1: Each `irq_o[k]` is high exactly when status bit k and enable bit k are both set, and it follows a change of either register from the cycle after the clock edge that changes it.
- R2: Byte addresses are as follows, and every other address is unused:
  - 0x000 holds the interrupt enable.
  - 0x004 holds the interrupt status.
  - 0x0F0 and 0x0F4 are scratch words that are stored and read back.
  - Channel k (0 to 5) occupies base 0x010*(k+1), with control at +0x0, interval at +0x4 and count at +0x8.
- R3: The control fields are:
  - bit 0 enables counting;
  - bit 1 is the reload request;
  - bits [3:2] select tick input 0 to 3;
  - bits [6:4] hold n, the prescaler exponent;
  - bit 7 selects one-shot mode when set and periodic mode when clear.

  The control register reads back as written, apart from the self-clear in R7.
- R4: A control write restarts the prescaler with the new source and exponent. It loads the count from the interval when bit 1 is set and leaves the count unchanged otherwise. It then runs or stops the channel according to bit 0.
- R5: While enabled, every 2^n-th pulse of the selected tick decrements the count. The decrement from 1 to 0 sets the channel's status bit. A prescaled tick while the count is 0 reloads the interval.
- R6: Writing the interval register stores the value and also loads the count with it, whether or not the channel is running.
- R7: In one-shot mode an expiry sets the status bit, clears control bit 0 by itself and leaves the count at 0.
- R8: Writing the status register clears each bit written as one. An expiry in the same cycle as the write keeps its bit set.
- R9: Writing the enable register replaces all six enable bits.
- R10: Reading the count register returns the live count. Writes to the count register have no effect.
- R11: A channel that is disabled, or whose selected tick input stays low, keeps its count.
- R12: Reads of unused addresses return zero. Writes to them change nothing.
- R13: After reset, every control register reads 0x04 (tick input 1, n=0, stopped). Intervals, counts, enable, status and scratch words read 0, and all interrupt outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel_i | input | 1 | Register access in this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 10 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the address |
| tick_i | input | 4 | Tick-enable pulses of the four time bases |
| irq_o | output | 6 | Per-channel interrupt levels |

## Verification
A write is taken at the rising edge where `bus_sel_i` and `bus_wr_i` are both high. Its effect on the registers and on `irq_o` is therefore due one edge later. Read data is combinational, so it reflects the register state in the same cycle as the address. An expiry raises the status bit and the interrupt at the edge that carries the final prescaled tick.

The bench drives and samples only on the falling edge, half a period away from any update. Its behavioural model steps on every rising edge, so each comparison sees exactly one edge of change on both sides. Directed reads of settled values (one-shot self-clear, stalled counts, reload-on-control) are placed only after waits long enough that the expected value is fixed.

// File: rtl/pit_pkg.sv
package pit_pkg;
   // control field positions fixed by the register layout
   localparam int EN_BIT  = 0;
   localparam int RLD_BIT = 1;
   localparam int SRC_LSB = 2;

   // global register offsets inside the 256-byte window
   localparam logic [7:0] OFS_IRQ_EN = 8'h00;
   localparam logic [7:0] OFS_IRQ_ST = 8'h04;
   localparam logic [7:0] OFS_SCR0   = 8'hF0;
   localparam logic [7:0] OFS_SCR1   = 8'hF4;

   // register selector inside a channel slot
   localparam logic [3:0] SLOT_CTRL = 4'h0;
   localparam logic [3:0] SLOT_INTV = 4'h4;
   localparam logic [3:0] SLOT_CNT  = 4'h8;

   function automatic int ctrl_width(input int src_w, input int pre_w);
      return SRC_LSB + src_w + pre_w + 1;
   endfunction
endpackage

// File: rtl/pit_prescaler.sv
module pit_prescaler #(
   parameter int PRE_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic             tick_i,
   input  logic [PRE_W-1:0] shift_i,
   output logic             tick_o
);
   localparam int DIV_W = (1 << PRE_W) - 1;

   logic [DIV_W-1:0] acc_q;
   logic [DIV_W-1:0] limit;
   logic             hit;

   // limit = 2^shift - 1 as a right-aligned mask
   assign limit  = {DIV_W{1'b1}} >> (DIV_W - int'(shift_i));
   assign hit    = (acc_q == limit);
   assign tick_o = tick_i & hit;

   always_ff @(posedge clk) begin
      if (!rst_n)       acc_q <= '0;
      else if (clear_i) acc_q <= '0;
      else if (tick_i)  acc_q <= hit ? '0 : acc_q + 1'b1;
   end
endmodule

// File: rtl/pit_channel.sv
module pit_channel
   import pit_pkg::*;
#(
   parameter int CNT_W  = 32,
   parameter int DATA_W = 32,
   parameter int SRC_W  = 2,
   parameter int PRE_W  = 3,
   parameter int CTRL_W = ctrl_width(SRC_W, PRE_W),
   parameter logic [CTRL_W-1:0] CTRL_RST = '0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [(1<<SRC_W)-1:0] src_tick_i,
   input  logic                  ctrl_we_i,
   input  logic                  intv_we_i,
   input  logic [DATA_W-1:0]     wdata_i,
   output logic [CTRL_W-1:0]     ctrl_o,
   output logic [CNT_W-1:0]      intv_o,
   output logic [CNT_W-1:0]      count_o,
   output logic                  expire_o
);
   localparam int PRE_LSB  = SRC_LSB + SRC_W;
   localparam int MODE_BIT = PRE_LSB + PRE_W;

   logic [CTRL_W-1:0] ctrl_q;
   logic [CNT_W-1:0]  intv_q, count_q;
   logic [SRC_W-1:0]  src_sel;
   logic [PRE_W-1:0]  shift;
   logic              running, src_act, ptick;

   assign running = ctrl_q[EN_BIT];
   assign src_sel = ctrl_q[SRC_LSB +: SRC_W];
   assign shift   = ctrl_q[PRE_LSB +: PRE_W];
   assign src_act = src_tick_i[src_sel];

   pit_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (ctrl_we_i),
      .tick_i  (running & src_act),
      .shift_i (shift),
      .tick_o  (ptick)
   );

   // a register write in the same cycle takes over the count
   assign expire_o = ptick & (count_q == CNT_W'(1)) & ~ctrl_we_i & ~intv_we_i;

   always_ff @(posedge clk) begin
      if (!rst_n)
         ctrl_q <= CTRL_RST;
      else if (ctrl_we_i)
         ctrl_q <= wdata_i[CTRL_W-1:0];
      else if (expire_o && ctrl_q[MODE_BIT])
         ctrl_q[EN_BIT] <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         intv_q  <= '0;
         count_q <= '0;
      end else if (ctrl_we_i) begin
         if (wdata_i[RLD_BIT]) count_q <= intv_q;
      end else if (intv_we_i) begin
         intv_q  <= wdata_i[CNT_W-1:0];
         count_q <= wdata_i[CNT_W-1:0];
      end else if (ptick) begin
         count_q <= (count_q == '0) ? intv_q : count_q - 1'b1;
      end
   end

   assign ctrl_o  = ctrl_q;
   assign intv_o  = intv_q;
   assign count_o = count_q;
endmodule

// File: rtl/pit_irq_ctrl.sv
module pit_irq_ctrl #(
   parameter int NUM_CH = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_we_i,
   input  logic              st_we_i,
   input  logic [NUM_CH-1:0] wbits_i,
   input  logic [NUM_CH-1:0] expire_i,
   output logic [NUM_CH-1:0] enable_o,
   output logic [NUM_CH-1:0] status_o,
   output logic [NUM_CH-1:0] irq_o
);
   logic [NUM_CH-1:0] enable_q, status_q, clr_mask;

   assign clr_mask = st_we_i ? wbits_i : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         enable_q <= '0;
         status_q <= '0;
      end else begin
         if (en_we_i) enable_q <= wbits_i;
         // expiry is applied after the clear, so it wins a tie
         status_q <= (status_q & ~clr_mask) | expire_i;
      end
   end

   assign enable_o = enable_q;
   assign status_o = status_q;
   assign irq_o    = status_q & enable_q;
endmodule

// File: rtl/pit_timer_bank.sv
module pit_timer_bank
   import pit_pkg::*;
#(
   parameter int NUM_CH  = 6,
   parameter int CNT_W   = 32,
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 10,
   parameter int SRC_W   = 2,
   parameter int PRE_W   = 3,
   parameter int DEF_SRC = 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bus_sel_i,
   input  logic                  bus_wr_i,
   input  logic [ADDR_W-1:0]     bus_addr_i,
   input  logic [DATA_W-1:0]     bus_wdata_i,
   output logic [DATA_W-1:0]     bus_rdata_o,
   input  logic [(1<<SRC_W)-1:0] tick_i,
   output logic [NUM_CH-1:0]     irq_o
);
   localparam int CTRL_W = ctrl_width(SRC_W, PRE_W);
   localparam logic [CTRL_W-1:0] CTRL_RST = CTRL_W'(DEF_SRC << SRC_LSB);

   // elaboration-time parameter checks
   if (NUM_CH < 1 || NUM_CH > 14) begin : g_bad_nch
      $error("NUM_CH must be 1..14");
   end
   if (CNT_W > DATA_W || CTRL_W > DATA_W || NUM_CH > DATA_W) begin : g_bad_w
      $error("register fields wider than the data bus");
   end
   if (ADDR_W < 9) begin : g_bad_aw
      $error("ADDR_W must be at least 9");
   end
   if (PRE_W < 1 || PRE_W > 4) begin : g_bad_pre
      $error("PRE_W must be 1..4");
   end
   if (DEF_SRC >= (1 << SRC_W)) begin : g_bad_src
      $error("DEF_SRC out of range");
   end

   logic                           wr_stb, in_win;
   logic [7:0]                     low_byte;
   logic [3:0]                     slot, reg_sel;
   logic [NUM_CH-1:0]              exp_vec, enable, status;
   logic [NUM_CH-1:0][CNT_W-1:0]   cnt_all, intv_all;
   logic [NUM_CH-1:0][CTRL_W-1:0]  ctrl_all;
   logic [NUM_CH-1:0][DATA_W-1:0]  cnt_rd, intv_rd;
   logic [DATA_W-1:0]              scr_q [2];

   assign wr_stb   = bus_sel_i & bus_wr_i;
   assign in_win   = (bus_addr_i[ADDR_W-1:8] == '0);
   assign low_byte = bus_addr_i[7:0];
   assign slot     = bus_addr_i[7:4];
   assign reg_sel  = bus_addr_i[3:0];

   for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
      logic hit;
      assign hit = in_win & (slot == 4'(k + 1));

      pit_channel #(
         .CNT_W(CNT_W), .DATA_W(DATA_W), .SRC_W(SRC_W), .PRE_W(PRE_W),
         .CTRL_W(CTRL_W), .CTRL_RST(CTRL_RST)
      ) u_ch (
         .clk        (clk),
         .rst_n      (rst_n),
         .src_tick_i (tick_i),
         .ctrl_we_i  (wr_stb & hit & (reg_sel == SLOT_CTRL)),
         .intv_we_i  (wr_stb & hit & (reg_sel == SLOT_INTV)),
         .wdata_i    (bus_wdata_i),
         .ctrl_o     (ctrl_all[k]),
         .intv_o     (intv_all[k]),
         .count_o    (cnt_all[k]),
         .expire_o   (exp_vec[k])
      );

      if (CNT_W == DATA_W) begin : g_full
         assign cnt_rd[k]  = cnt_all[k];
         assign intv_rd[k] = intv_all[k];
      end else begin : g_pad
         assign cnt_rd[k]  = {{(DATA_W-CNT_W){1'b0}}, cnt_all[k]};
         assign intv_rd[k] = {{(DATA_W-CNT_W){1'b0}}, intv_all[k]};
      end
   end

   pit_irq_ctrl #(.NUM_CH(NUM_CH)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_we_i  (wr_stb & in_win & (low_byte == OFS_IRQ_EN)),
      .st_we_i  (wr_stb & in_win & (low_byte == OFS_IRQ_ST)),
      .wbits_i  (bus_wdata_i[NUM_CH-1:0]),
      .expire_i (exp_vec),
      .enable_o (enable),
      .status_o (status),
      .irq_o    (irq_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         scr_q[0] <= '0;
         scr_q[1] <= '0;
      end else if (wr_stb && in_win) begin
         if (low_byte == OFS_SCR0) scr_q[0] <= bus_wdata_i;
         if (low_byte == OFS_SCR1) scr_q[1] <= bus_wdata_i;
      end
   end

   always_comb begin
      bus_rdata_o = '0;
      if (in_win) begin
         case (low_byte)
            OFS_IRQ_EN: bus_rdata_o = DATA_W'(enable);
            OFS_IRQ_ST: bus_rdata_o = DATA_W'(status);
            OFS_SCR0:   bus_rdata_o = scr_q[0];
            OFS_SCR1:   bus_rdata_o = scr_q[1];
            default:    ;
         endcase
         for (int k = 0; k < NUM_CH; k++) begin
            if (slot == 4'(k + 1)) begin
               case (reg_sel)
                  SLOT_CTRL: bus_rdata_o = DATA_W'(ctrl_all[k]);
                  SLOT_INTV: bus_rdata_o = intv_rd[k];
                  SLOT_CNT:  bus_rdata_o = cnt_rd[k];
                  default:   bus_rdata_o = '0;
               endcase
            end
         end
      end
   end
endmodule

// File: rtl/pit_timer_bank_chk.sv
module pit_timer_bank_chk #(
   parameter int NUM_CH   = 6,
   parameter int CNT_W    = 32,
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 10,
   parameter int SRC_W    = 2,
   parameter int CTRL_W   = 8,
   parameter int MODE_BIT = 7
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          bus_sel_i,
   input logic                          bus_wr_i,
   input logic [ADDR_W-1:0]             bus_addr_i,
   input logic [DATA_W-1:0]             bus_wdata_i,
   input logic [(1<<SRC_W)-1:0]         tick_i,
   input logic [NUM_CH-1:0]             irq_o,
   input logic [NUM_CH-1:0][CNT_W-1:0]  cnt_all,
   input logic [NUM_CH-1:0][CTRL_W-1:0] ctrl_all,
   input logic [NUM_CH-1:0]             exp_vec
);
   logic wr_stb, quiet;
   assign wr_stb = bus_sel_i & bus_wr_i;
   assign quiet  = (tick_i == '0);

   // R9: clearing the whole enable mask silences every line
   assert_mask_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb && bus_addr_i == ADDR_W'(0) && bus_wdata_i[NUM_CH-1:0] == '0
      |=> irq_o == '0);

   // R8: clearing all status bits with no concurrent expiry drops every line
   assert_w1c_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb && bus_addr_i == ADDR_W'(4) && bus_wdata_i[NUM_CH-1:0] == '1 && exp_vec == '0
      |=> irq_o == '0);

   // R11: no tick and no write leaves every count where it was
   assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      quiet && !wr_stb |=> $stable(cnt_all));

   // R12: a write outside the register window touches no channel state
   assert_outside_wr_R12: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb && bus_addr_i[ADDR_W-1:8] != '0 && quiet
      |=> $stable(ctrl_all) && $stable(cnt_all));

   for (genvar k = 0; k < NUM_CH; k++) begin : g_ch_chk
      // R6: an interval write lands in the count one edge later
      assert_intv_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
         wr_stb && bus_addr_i == ADDR_W'((k + 1) * 16 + 4)
         |=> cnt_all[k] == $past(bus_wdata_i[CNT_W-1:0]));

      // R7: a one-shot expiry switches the channel off
      assert_oneshot_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
         exp_vec[k] && ctrl_all[k][MODE_BIT] |=> !ctrl_all[k][0]);
   end
endmodule

bind pit_timer_bank pit_timer_bank_chk #(
   .NUM_CH(NUM_CH), .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
   .SRC_W(SRC_W), .CTRL_W(CTRL_W), .MODE_BIT(CTRL_W - 1)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_sel_i   (bus_sel_i),
   .bus_wr_i    (bus_wr_i),
   .bus_addr_i  (bus_addr_i),
   .bus_wdata_i (bus_wdata_i),
   .tick_i      (tick_i),
   .irq_o       (irq_o),
   .cnt_all     (cnt_all),
   .ctrl_all    (ctrl_all),
   .exp_vec     (exp_vec)
);

// File: tb/pit_timer_bank_bench.sv
module pit_timer_bank_bench;
   localparam int NCH = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [9:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [3:0]  tick = '0;
   logic [31:0] rdata;
   logic [5:0]  irq;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   pit_timer_bank u_pit_timer_bank (
      .clk(clk), .rst_n(rst_n), .bus_sel_i(bus_sel), .bus_wr_i(bus_wr),
      .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(rdata),
      .tick_i(tick), .irq_o(irq)
   );

   // ---------------- behavioural reference model ----------------
   logic [7:0]  m_ctrl [NCH];
   logic [31:0] m_intv [NCH];
   logic [31:0] m_cnt  [NCH];
   int          m_pre  [NCH];
   logic [5:0]  m_en, m_st;
   logic [31:0] m_scr [2];

   always @(posedge clk) begin : model
      logic [5:0] ex;
      logic       wr_now;
      ex = '0;
      wr_now = bus_sel && bus_wr;
      if (!rst_n) begin
         for (int k = 0; k < NCH; k++) begin
            m_ctrl[k] = 8'h04; m_intv[k] = 0; m_cnt[k] = 0; m_pre[k] = 0;
         end
         m_en = 0; m_st = 0; m_scr[0] = 0; m_scr[1] = 0;
      end else begin
         for (int k = 0; k < NCH; k++) begin
            logic [7:0] c;
            logic run, t, pt, cw, iw;
            int mask;
            c    = m_ctrl[k];
            run  = c[0];
            t    = tick[c[3:2]];
            mask = (1 << c[6:4]) - 1;
            pt   = run && t && (m_pre[k] == mask);
            cw   = wr_now && bus_addr == 10'((k + 1) * 16);
            iw   = wr_now && bus_addr == 10'((k + 1) * 16 + 4);
            if (cw) m_pre[k] = 0;
            else if (run && t) m_pre[k] = (m_pre[k] == mask) ? 0 : m_pre[k] + 1;
            ex[k] = pt && (m_cnt[k] == 1) && !cw && !iw;
            if (cw) begin
               if (bus_wdata[1]) m_cnt[k] = m_intv[k];
               m_ctrl[k] = bus_wdata[7:0];
            end else if (iw) begin
               m_intv[k] = bus_wdata;
               m_cnt[k]  = bus_wdata;
            end else if (pt) begin
               m_cnt[k] = (m_cnt[k] == 0) ? m_intv[k] : m_cnt[k] - 1;
            end
            if (ex[k] && c[7]) m_ctrl[k][0] = 1'b0;
         end
         if (wr_now && bus_addr == 10'h004) m_st = m_st & ~bus_wdata[5:0];
         m_st = m_st | ex;
         if (wr_now && bus_addr == 10'h000) m_en = bus_wdata[5:0];
         if (wr_now && bus_addr == 10'h0F0) m_scr[0] = bus_wdata;
         if (wr_now && bus_addr == 10'h0F4) m_scr[1] = bus_wdata;
      end
   end

   function automatic logic [31:0] m_read(input logic [9:0] a);
      int s;
      if (a[9:8] != 0) return 0;
      case (a[7:0])
         8'h00: return {26'b0, m_en};
         8'h04: return {26'b0, m_st};
         8'hF0: return m_scr[0];
         8'hF4: return m_scr[1];
         default: ;
      endcase
      s = int'(a[7:4]);
      if (s >= 1 && s <= NCH) begin
         case (a[3:0])
            4'h0: return {24'b0, m_ctrl[s-1]};
            4'h4: return m_intv[s-1];
            4'h8: return m_cnt[s-1];
            default: return 0;
         endcase
      end
      return 0;
   endfunction

   function automatic string tag_for(input logic [9:0] a);
      int s;
      if (a[9:8] != 0) return "R12";
      if (a[7:0] == 8'h00) return "R9";
      if (a[7:0] == 8'h04) return "R8";
      if (a[7:0] == 8'hF0 || a[7:0] == 8'hF4) return "R2";
      s = int'(a[7:4]);
      if (s < 1 || s > NCH) return "R12";
      case (a[3:0])
         4'h0: return "R3";
         4'h4: return "R6";
         4'h8: return "R5";
         default: return "R12";
      endcase
   endfunction

   // ---------------- checking helpers ----------------
   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   logic [31:0] last_rd;

   // one clock; compares on the falling edge, away from the update edge
   task automatic step();
      @(negedge clk);
      check("R1", {26'b0, irq}, {26'b0, m_st & m_en});
      if (bus_sel && !bus_wr) check(tag_for(bus_addr), rdata, m_read(bus_addr));
      last_rd = rdata;
   endtask

   task automatic idle(input int n);
      bus_sel = 0; bus_wr = 0;
      repeat (n) step();
   endtask

   task automatic wr(input logic [9:0] a, input logic [31:0] d);
      bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
      step();
      bus_sel = 0; bus_wr = 0;
   endtask

   task automatic rd(input logic [9:0] a, output logic [31:0] d);
      bus_sel = 1; bus_wr = 0; bus_addr = a;
      step();
      d = last_rd;
      bus_sel = 0;
   endtask

   task automatic rd_loop(input logic [9:0] a, input int n);
      logic [31:0] d;
      for (int i = 0; i < n; i++) rd(a, d);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   // tick sources: 0 every cycle, 1 every third, 2 never, 3 every other
   initial begin
      int cyc;
      cyc = 0;
      forever begin
         @(negedge clk);
         cyc++;
         tick[0] = 1'b1;
         tick[1] = (cyc % 3 == 0);
         tick[2] = 1'b0;
         tick[3] = cyc[0];
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   // ---------------- stimulus ----------------
   initial begin
      logic [31:0] v, v1, v2;
      repeat (3) @(negedge clk);
      rst_n = 1;
      step();

      // R13 reset state
      rd(10'h010, v); check("R13", v, 32'h04);
      rd(10'h060, v); check("R13", v, 32'h04);
      rd(10'h000, v); check("R13", v, 0);
      rd(10'h004, v); check("R13", v, 0);
      rd(10'h018, v); check("R13", v, 0);
      rd(10'h0F0, v); check("R13", v, 0);
      check("R13", {26'b0, irq}, 0);

      wr(10'h000, 32'h3F);
      rd(10'h000, v); check("R9", v, 32'h3F);

      // ch0 periodic, source 0, n=0, interval 5
      wr(10'h014, 5);
      wr(10'h010, 32'h03);
      rd_loop(10'h018, 20);
      rd(10'h004, v); check("R5", v & 1, 1);

      // ch1 one-shot, source 1, n=1, interval 3
      wr(10'h024, 3);
      wr(10'h020, 32'h97);
      rd_loop(10'h028, 50);
      rd(10'h020, v); check("R7", v, 32'h96);
      rd(10'h028, v); check("R7", v, 0);
      rd(10'h004, v); check("R7", v & 2, 2);

      // status write-one-to-clear on ch1 only
      wr(10'h004, 32'h02);
      rd(10'h004, v); check("R8", v & 2, 0);

      // ch2 on a source that never pulses
      wr(10'h034, 9);
      wr(10'h030, 32'h0B);
      idle(20);
      rd(10'h038, v); check("R11", v, 9);
      wr(10'h038, 32'h77);
      rd(10'h038, v); check("R10", v, 9);

      // ch3 periodic, source 3, n=2, interval 2
      wr(10'h044, 2);
      wr(10'h040, 32'h2F);
      rd_loop(10'h048, 40);
      rd(10'h040, v); check("R3", v, 32'h2F);

      // ch4: control write ordering and reload bit
      wr(10'h054, 10);
      wr(10'h050, 32'h01);
      idle(4);
      wr(10'h050, 32'h00);
      rd(10'h058, v1);
      idle(5);
      rd(10'h058, v2);
      check("R4", v2, v1);
      check("R4", (v1 < 10) ? 1 : 0, 1);
      wr(10'h050, 32'h02);
      rd(10'h058, v); check("R4", v, 10);

      // interval rewrite while ch0 is running
      wr(10'h014, 2);
      rd(10'h014, v); check("R6", v, 2);
      rd_loop(10'h018, 12);

      // clear all, periodic ch0 fires again
      wr(10'h004, 32'h3F);
      idle(10);
      rd(10'h004, v); check("R5", v & 1, 1);

      // unused addresses
      wr(10'h01C, 32'hFFFF_FFFF);
      wr(10'h0A0, 32'hFFFF_FFFF);
      wr(10'h210, 32'hFFFF_FFFF);
      rd(10'h01C, v); check("R12", v, 0);
      rd(10'h0A0, v); check("R12", v, 0);
      rd(10'h210, v); check("R12", v, 0);
      rd(10'h010, v); check("R12", v, 32'h03);

      // scratch words
      wr(10'h0F0, 32'hDEAD_BEEF);
      wr(10'h0F4, 32'h1234_5678);
      rd(10'h0F0, v); check("R2", v, 32'hDEAD_BEEF);
      rd(10'h0F4, v); check("R2", v, 32'h1234_5678);

      // mask everything off
      wr(10'h000, 0);
      check("R9", {26'b0, irq}, 0);
      idle(10);

      summary();
      $finish;
   end
endmodule